// File: doc/BRIEF.md
# Quadrature to Up/Down Pulse Converter

This block turns the two phase-shifted tracks of an incremental encoder into counting pulses for a downstream up/down counter. Both tracks first pass through a two-flop synchronizer on the system clock. A joint validation filter then accepts a new track pair only after it has been seen unchanged for `FILT_CYCLES` consecutive samples. Each accepted change is classified by direction and by the selected resolution. A qualifying change produces one active-low pulse whose width, in clock cycles, is set by a run-time input.

An emitted pulse holds the filter idle until the pulse ends. An encoder that dithers across an edge therefore cannot produce a burst of spurious counts. A parameter selects one of two output formats. In the split format the block drives separate up and down pulse lines. In the combined format it drives one pulse line and a direction level; a counter that counts on the rising edge of that line sees a settled direction.

Top module: `qpc_converter`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out0_n` and `out1` are high and `step_err` is low. In the combined format, high on `out1` means up.
- R2: With `res_mode` 2'b10 or 2'b11 (x4), every accepted single-track change gives one pulse. A full quadrature cycle in the up direction gives 4 pulses on the up line and none on the down line. The pair sequence for up is AB 00,10,11,01, meaning A leads B.
- R3: In the down direction (AB 00,01,11,10, meaning A lags B), pulses appear only on the down line. In the split format `out1` is the down line.
- R4: With `res_mode` 2'b01 (x2), only changes of A give pulses, so each quadrature cycle gives 2 pulses.
- R5: With `res_mode` 2'b00 (x1), one pulse is given per cycle. A rise of A while B is low counts up, and a fall of A while B is low counts down.
- R6: A pulse stays low for exactly `pw_cycles` clock cycles. A value of 0 gives a width of 1.
- R7: A track level that differs from the accepted state for fewer than `FILT_CYCLES` samples produces no pulse.
- R8: While a pulse is low, track changes are neither validated nor decoded. A change that is undone before the pulse ends produces no pulse and no error.
- R9: A change in which A and B flip in the same accepted sample produces no pulse and raises `step_err` for exactly one cycle.
- R10: In the combined format, `out0_n` carries every pulse and `out1` holds the direction of the current pulse. `out1` stays stable while `out0_n` is low, so it is valid at the rising edge.
- R11: In the split format, the up and down lines are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder track A, asynchronous |
| enc_b | input | 1 | Encoder track B, asynchronous |
| res_mode | input | 2 | Resolution: 00 x1, 01 x2, 10 or 11 x4 |
| pw_cycles | input | PW_BITS | Pulse width in clock cycles (0 is treated as 1) |
| out0_n | output | 1 | Split: up pulse, active low. Combined: count pulse, active low |
| out1 | output | 1 | Split: down pulse, active low. Combined: direction, high means up |
| step_err | output | 1 | One-cycle flag for a two-track change |

## Verification
The bench goes after dither during a pulse by toggling B and restoring it inside a long pulse. A design without the inhibit window would emit an up pulse and then a down pulse. Glitches one sample shorter than the validation interval are applied; an off-by-one filter would count them. All four mode codes are run in both directions so that the x1 edge choice shows up. A design that used the wrong A edge, or that let B changes through in x2, would give the wrong count on the wrong line. Simultaneous two-track changes must raise a single error cycle with no pulse. The combined-format instance is checked for the direction level seen at each rising edge, and a zero width setting must still give a one-cycle pulse.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Resolution codes seen on res_mode
    typedef enum logic [1:0] {
        RES_X1  = 2'b00,
        RES_X2  = 2'b01,
        RES_X4  = 2'b10,
        RES_X4B = 2'b11
    } res_e;

    // Accepted track pair
    typedef struct packed {
        logic a;
        logic b;
    } trk_t;

    // Result of classifying one accepted change
    typedef struct packed {
        logic fire;   // emit a pulse
        logic up;     // direction of that pulse
        logic bad;    // both tracks moved together
    } step_t;

    // Direction of a single-track change: A leading B counts up
    function automatic logic step_is_up(trk_t prv, trk_t cur);
        logic a_moved;
        a_moved = prv.a ^ cur.a;
        if (a_moved) begin
            return cur.a != cur.b;
        end
        return cur.b == cur.a;
    endfunction

    // Whether a given single-track change counts at the chosen resolution
    function automatic logic step_counts(trk_t prv, trk_t cur, res_e mode);
        logic a_moved;
        a_moved = prv.a ^ cur.a;
        case (mode)
            RES_X1:  return a_moved && !cur.b;
            RES_X2:  return a_moved;
            default: return 1'b1;
        endcase
    endfunction

    function automatic step_t classify(trk_t prv, trk_t cur, res_e mode);
        step_t r;
        logic [1:0] diff;
        diff   = {prv.a ^ cur.a, prv.b ^ cur.b};
        r.bad  = (diff == 2'b11);
        r.up   = step_is_up(prv, cur);
        r.fire = (diff == 2'b10 || diff == 2'b01) && step_counts(prv, cur, mode);
        return r;
    endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/qpc_glitch_filter.sv
module qpc_glitch_filter
    import qpc_pkg::*;
#(
    parameter int FILT_CYCLES = 4   // must be 2 or more
) (
    input  logic clk,
    input  logic rst,
    input  trk_t smp,       // synchronized sample
    input  logic hold,      // inhibit window: freeze validation
    output trk_t acc,       // accepted state
    output trk_t acc_prev,  // state before the last acceptance
    output logic strobe     // one cycle after each acceptance
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    trk_t          cand;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            acc_prev <= '0;
            cand     <= '0;
            cnt      <= '0;
            strobe   <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (hold || smp == acc) begin
                cand <= acc;
                cnt  <= '0;
            end else if (smp != cand) begin
                cand <= smp;
                cnt  <= CW'(1);
            end else if (cnt == LAST) begin
                acc_prev <= acc;
                acc      <= smp;
                strobe   <= 1'b1;
                cnt      <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/qpc_step_decode.sv
module qpc_step_decode
    import qpc_pkg::*;
(
    input  logic  strobe,
    input  trk_t  acc_prev,
    input  trk_t  acc,
    input  res_e  mode,
    output step_t step
);
    step_t raw;

    always_comb begin
        raw  = classify(acc_prev, acc, mode);
        step = '0;
        if (strobe) begin
            step = raw;
        end
    end
endmodule

// File: rtl/qpc_pulse_gen.sv
module qpc_pulse_gen
    import qpc_pkg::*;
#(
    parameter int PW_BITS  = 8,
    parameter bit COMBINED = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  step_t              step,
    input  logic [PW_BITS-1:0] pw_cycles,
    output logic               active,
    output logic               line0_n,
    output logic               line1
);
    logic [PW_BITS-1:0] left;
    logic               dir_q;
    logic [PW_BITS-1:0] pw_eff;

    assign pw_eff = (pw_cycles == '0) ? PW_BITS'(1) : pw_cycles;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            left   <= '0;
            dir_q  <= 1'b1;
        end else if (active) begin
            if (left == PW_BITS'(1)) active <= 1'b0;
            left <= left - PW_BITS'(1);
        end else if (step.fire) begin
            active <= 1'b1;
            left   <= pw_eff;
            dir_q  <= step.up;
        end
    end

    generate
        if (COMBINED) begin : g_comb
            assign line0_n = !active;
            assign line1   = dir_q;
        end else begin : g_split
            assign line0_n = !(active && dir_q);
            assign line1   = !(active && !dir_q);
        end
    endgenerate
endmodule

// File: rtl/qpc_converter.sv
module qpc_converter
    import qpc_pkg::*;
#(
    parameter int FILT_CYCLES = 4,
    parameter int PW_BITS     = 8,
    parameter bit COMBINED    = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enc_a,
    input  logic               enc_b,
    input  logic [1:0]         res_mode,
    input  logic [PW_BITS-1:0] pw_cycles,
    output logic               out0_n,
    output logic               out1,
    output logic               step_err
);
    logic [1:0] ab_sync;
    trk_t       smp, acc, acc_prev;
    logic       strobe, active;
    step_t      step;

    qpc_sync #(.WIDTH(2), .STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .d_async({enc_a, enc_b}), .d_sync(ab_sync)
    );

    assign smp = trk_t'(ab_sync);

    qpc_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) i_filt (
        .clk(clk), .rst(rst), .smp(smp), .hold(active || strobe),
        .acc(acc), .acc_prev(acc_prev), .strobe(strobe)
    );

    qpc_step_decode i_dec (
        .strobe(strobe), .acc_prev(acc_prev), .acc(acc),
        .mode(res_e'(res_mode)), .step(step)
    );

    qpc_pulse_gen #(.PW_BITS(PW_BITS), .COMBINED(COMBINED)) i_pulse (
        .clk(clk), .rst(rst), .step(step), .pw_cycles(pw_cycles),
        .active(active), .line0_n(out0_n), .line1(out1)
    );

    assign step_err = step.bad;
endmodule

// File: rtl/qpc_converter_chk.sv
module qpc_converter_chk #(
    parameter int PW_BITS  = 8,
    parameter bit COMBINED = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic out0_n,
    input logic out1,
    input logic step_err
);
    localparam int RUN_MAX = (1 << PW_BITS) - 1;

    logic        pulse_low;
    logic [31:0] run_len;

    assign pulse_low = COMBINED ? !out0_n : (!out0_n || !out1);

    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (pulse_low) run_len <= run_len + 32'd1;
        else                run_len <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (out0_n && out1 && !step_err)); // R1

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_err |=> !step_err); // R9

    AST_NO_ERR_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        pulse_low |-> !step_err); // R8

    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_len <= 32'(RUN_MAX)); // R6

    generate
        if (COMBINED) begin : g_comb
            AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
                (!out0_n && $past(!out0_n)) |-> $stable(out1)); // R10
        end else begin : g_split
            AST_LINES_EXCL: assert property (@(posedge clk) disable iff (rst)
                !(!out0_n && !out1)); // R11
        end
    endgenerate
endmodule

bind qpc_converter qpc_converter_chk #(.PW_BITS(PW_BITS), .COMBINED(COMBINED)) i_chk (
    .clk(clk), .rst(rst), .out0_n(out0_n), .out1(out1), .step_err(step_err)
);

// File: tb/test_qpc_converter.sv
module test_qpc_converter;
    localparam int FILT = 4;
    localparam int HOLD = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a = 1'b0, b = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [7:0] pw = 8'd6;
    logic       o0, o1, err;
    logic       c0, c1, cerr;

    int total = 0, bad = 0;
    int idx = 0;

    int up_n = 0, dn_n = 0, err_n = 0, both_n = 0, last_w = 0, run0 = 0;
    int cup_n = 0, cdn_n = 0;
    logic p0 = 1'b1, p1 = 1'b1, pc = 1'b1;

    always #2.5 clk = !clk;

    qpc_converter #(.FILT_CYCLES(FILT), .PW_BITS(8), .COMBINED(1'b0)) i_qpc_converter (
        .clk(clk), .rst(rst), .enc_a(a), .enc_b(b), .res_mode(mode),
        .pw_cycles(pw), .out0_n(o0), .out1(o1), .step_err(err)
    );

    qpc_converter #(.FILT_CYCLES(FILT), .PW_BITS(8), .COMBINED(1'b1)) i_qpc_converter_comb (
        .clk(clk), .rst(rst), .enc_a(a), .enc_b(b), .res_mode(mode),
        .pw_cycles(pw), .out0_n(c0), .out1(c1), .step_err(cerr)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!o0 && p0) up_n++;
            if (!o1 && p1) dn_n++;
            if (!o0) run0++;
            else if (!p0) begin last_w = run0; run0 = 0; end
            if (err) err_n++;
            if (!o0 && !o1) both_n++;
            if (c0 && !pc) begin
                if (c1) cup_n++;
                else    cdn_n++;
            end
        end
        p0 = o0; p1 = o1; pc = c0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(posedge clk);
        up_n = 0; dn_n = 0; err_n = 0; both_n = 0; cup_n = 0; cdn_n = 0;
    endtask

    task automatic drive_idx();
        case (idx & 3)
            0: begin a = 1'b0; b = 1'b0; end
            1: begin a = 1'b1; b = 1'b0; end
            2: begin a = 1'b1; b = 1'b1; end
            default: begin a = 1'b0; b = 1'b1; end
        endcase
    endtask

    task automatic step(input int dir);
        @(negedge clk);
        idx = (idx + dir) & 3;
        drive_idx();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(o0 == 1'b1 && o1 == 1'b1, "R1 split lines idle", {o0, o1}, 3);
        chk(c0 == 1'b1 && c1 == 1'b1, "R1 combined idle dir up", {c0, c1}, 3);
        chk(err == 1'b0, "R1 err low", err, 0);
    endtask

    task automatic t_rotate(input logic [1:0] m, input int dir, input int cyc,
                            input int exp_up, input int exp_dn, input string tag);
        mode = m;
        repeat (4) @(negedge clk);
        clear_counts();
        for (int i = 0; i < 4 * cyc; i++) step(dir);
        chk(up_n == exp_up, {tag, " up count"}, up_n, exp_up);
        chk(dn_n == exp_dn, {tag, " down count"}, dn_n, exp_dn);
    endtask

    task automatic t_width(input logic [7:0] w, input int exp_w);
        pw = w;
        mode = 2'b10;
        repeat (4) @(negedge clk);
        step(1);
        chk(last_w == exp_w, "R6 pulse width", last_w, exp_w);
        pw = 8'd6;
    endtask

    task automatic t_glitch();
        mode = 2'b10;
        repeat (4) @(negedge clk);
        clear_counts();
        @(negedge clk);
        a = !a;
        repeat (FILT - 1) @(negedge clk);
        a = !a;
        repeat (HOLD) @(negedge clk);
        chk(up_n + dn_n == 0, "R7 short glitch ignored", up_n + dn_n, 0);
    endtask

    task automatic t_inhibit();
        int guard;
        pw = 8'd30;
        mode = 2'b10;
        repeat (4) @(negedge clk);
        clear_counts();
        @(negedge clk);
        idx = (idx + 1) & 3;
        drive_idx();
        guard = 0;
        while ((o0 && o1) && guard < 50) begin @(negedge clk); guard++; end
        b = !b;
        repeat (8) @(negedge clk);
        b = !b;
        repeat (80) @(negedge clk);
        chk(up_n == 1, "R8 dither during pulse up count", up_n, 1);
        chk(dn_n == 0, "R8 dither during pulse down count", dn_n, 0);
        chk(err_n == 0, "R8 no error from dither", err_n, 0);
        pw = 8'd6;
    endtask

    task automatic t_invalid();
        mode = 2'b10;
        repeat (4) @(negedge clk);
        clear_counts();
        @(negedge clk);
        idx = (idx + 2) & 3;
        drive_idx();
        repeat (HOLD) @(negedge clk);
        chk(up_n + dn_n == 0, "R9 no pulse on double change", up_n + dn_n, 0);
        chk(err_n == 1, "R9 single error cycle", err_n, 1);
    endtask

    task automatic t_combined();
        mode = 2'b10;
        repeat (4) @(negedge clk);
        clear_counts();
        for (int i = 0; i < 4; i++) step(1);
        chk(cup_n == 4 && cdn_n == 0, "R10 combined up rises", cup_n * 10 + cdn_n, 40);
        clear_counts();
        for (int i = 0; i < 4; i++) step(-1);
        chk(cdn_n == 4 && cup_n == 0, "R10 combined down rises", cdn_n * 10 + cup_n, 40);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_rotate(2'b10, 1, 2, 8, 0, "R2 x4 up");
        t_rotate(2'b11, 1, 1, 4, 0, "R2 x4 alt code");
        t_rotate(2'b10, -1, 2, 0, 8, "R3 x4 down");
        t_rotate(2'b01, 1, 2, 4, 0, "R4 x2 up");
        t_rotate(2'b01, -1, 2, 0, 4, "R4 x2 down");
        t_rotate(2'b00, 1, 3, 3, 0, "R5 x1 up");
        t_rotate(2'b00, -1, 3, 0, 3, "R5 x1 down");
        t_width(8'd9, 9);
        t_width(8'd0, 1);
        t_glitch();
        t_inhibit();
        t_invalid();
        t_combined();
        chk(both_n == 0, "R11 lines never both low", both_n, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule